// File: doc/BRIEF.md
# Four-Stage Shift Register with Parallel Load and Rotate

This block is a small word register built from a chain of one-bit stages. All stages update together on each rising clock edge. A single mode select picks the operation. When it is low, the word moves one place toward the last stage. When it is high, every stage is written at once from the parallel input.

While shifting, the first stage takes its value from a feed point. The feed is either the external serial input or, when rotate is enabled, the current content of the last stage. In rotate mode the word circulates with no bit lost. The whole word is always visible on the parallel output, and the last stage also drives the serial output. A synchronous active-high reset clears the register and overrides every other operation.

Bit numbering: `word_out[3]` is the first stage and `word_out[0]` is the last stage. A shift therefore moves each bit from index i+1 to index i.

Top module: `shift_load_reg`

## Requirements
- R1: When `rst` is 1 at a rising edge, all four stages become 0, whatever the values of `mode_load`, `rot_en`, `ser_in` and `word_in`.
- R2: When `mode_load` is 1 and `rst` is 0 at a rising edge, stage i takes `word_in[i]` for every i, so `word_out` equals the sampled `word_in`.
- R3: When `mode_load` is 0 and `rst` is 0 at a rising edge, each stage at index i (0..2) takes the previous value of the stage at index i+1.
- R4: In shift mode with `rot_en` at 0, the first stage (`word_out[3]`) takes the sampled `ser_in`.
- R5: In shift mode with `rot_en` at 1, the first stage takes the previous value of the last stage (`word_out[0]`), and `ser_in` is ignored.
- R6: `ser_out` always equals the last stage, `word_out[0]`.
- R7: In load mode, `rot_en` and `ser_in` have no effect on the loaded word.
- R8: Four consecutive rotating shifts return the register to the word it held before them, and each rotate keeps the number of ones unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all stages update on its rising edge |
| rst | input | 1 | Synchronous active-high clear |
| mode_load | input | 1 | 0 selects a shift, 1 selects a parallel load |
| rot_en | input | 1 | While shifting, feed the last stage back into the first |
| ser_in | input | 1 | External serial data for the first stage |
| word_in | input | 4 | Parallel load data, bit i goes to stage i |
| word_out | output | 4 | All stages; bit 3 is first, bit 0 is last |
| ser_out | output | 1 | Content of the last stage |

## Verification
The assertions check every cycle that reset clears the word and overrides the other operations. They also check that a load copies the parallel input, that a shift moves each bit down one index, and that the first stage takes either the serial input or the old last bit, according to the rotate enable. They confirm that a rotate preserves the count of ones. Only the bench scenarios can show the full round trip: a word restored after four rotates in a row, a serial pattern streamed in bit by bit, and a load that ignores the rotate and serial inputs.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int unsigned SREG_STAGES = 4;

    typedef enum logic {
        OP_SHIFT = 1'b0,
        OP_LOAD  = 1'b1
    } sreg_op_e;

    typedef enum logic {
        FEED_EXTERNAL = 1'b0,
        FEED_WRAP     = 1'b1
    } sreg_feed_e;

    typedef struct packed {
        logic       clear;
        sreg_op_e   op;
        sreg_feed_e feed;
    } sreg_ctrl_t;

    function automatic sreg_ctrl_t decode_ctrl(input logic rst_i,
                                               input logic mode_i,
                                               input logic rot_i);
        sreg_ctrl_t c;
        c.clear = rst_i;
        c.op    = mode_i ? OP_LOAD : OP_SHIFT;
        c.feed  = rot_i ? FEED_WRAP : FEED_EXTERNAL;
        return c;
    endfunction

endpackage

// File: rtl/sreg_feed_sel.sv
module sreg_feed_sel
    import sreg_pkg::*;
(
    input  sreg_feed_e feed_i,
    input  logic       ser_i,
    input  logic       last_i,
    output logic       feed_o
);
    always_comb begin
        unique case (feed_i)
            FEED_WRAP:     feed_o = last_i;
            FEED_EXTERNAL: feed_o = ser_i;
            default:       feed_o = ser_i;
        endcase
    end
endmodule

// File: rtl/sreg_stage.sv
module sreg_stage
    import sreg_pkg::*;
(
    input  logic       clk,
    input  sreg_ctrl_t ctrl_i,
    input  logic       load_bit_i,
    input  logic       up_bit_i,
    output logic       q_o
);
    logic d;

    always_comb begin
        if (ctrl_i.clear)
            d = 1'b0;
        else if (ctrl_i.op == OP_LOAD)
            d = load_bit_i;
        else
            d = up_bit_i;
    end

    always_ff @(posedge clk) begin
        q_o <= d;
    end
endmodule

// File: rtl/shift_load_reg.sv
module shift_load_reg
    import sreg_pkg::*;
#(
    parameter int unsigned STAGES = SREG_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_load,
    input  logic              rot_en,
    input  logic              ser_in,
    input  logic [STAGES-1:0] word_in,
    output logic [STAGES-1:0] word_out,
    output logic              ser_out
);
    localparam int unsigned FIRST = STAGES - 1;

    sreg_ctrl_t ctrl;
    logic       feed;
    logic [STAGES-1:0] q;

    assign ctrl = decode_ctrl(rst, mode_load, rot_en);

    sreg_feed_sel u_feed (
        .feed_i (ctrl.feed),
        .ser_i  (ser_in),
        .last_i (q[0]),
        .feed_o (feed)
    );

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic up_bit;
        if (i == FIRST) begin : g_head
            assign up_bit = feed;
        end else begin : g_body
            assign up_bit = q[i+1];
        end
        sreg_stage u_stage (
            .clk        (clk),
            .ctrl_i     (ctrl),
            .load_bit_i (word_in[i]),
            .up_bit_i   (up_bit),
            .q_o        (q[i])
        );
    end

    assign word_out = q;
    assign ser_out  = q[0];

    p_clear_r1: assert property (@(posedge clk) rst |=> word_out == '0)
        else $error("R1 clear failed");

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        mode_load |=> word_out == $past(word_in))
        else $error("R2 load failed");

    p_shift_r3: assert property (@(posedge clk) disable iff (rst)
        !mode_load |=> word_out[FIRST-1:0] == $past(word_out[FIRST:1]))
        else $error("R3 shift failed");

    p_serial_feed_r4: assert property (@(posedge clk) disable iff (rst)
        (!mode_load && !rot_en) |=> word_out[FIRST] == $past(ser_in))
        else $error("R4 serial feed failed");

    p_wrap_feed_r5: assert property (@(posedge clk) disable iff (rst)
        (!mode_load && rot_en) |=> word_out[FIRST] == $past(word_out[0]))
        else $error("R5 wrap feed failed");

    p_rot_ones_r8: assert property (@(posedge clk) disable iff (rst)
        (!mode_load && rot_en) |=> $countones(word_out) == $countones($past(word_out)))
        else $error("R8 rotate lost a bit");

endmodule

// File: tb/shift_load_reg_bench.sv
module shift_load_reg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    typedef struct {
        logic [N-1:0] word;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst, mode_load, rot_en, ser_in;
    logic [N-1:0] word_in, word_out;
    logic ser_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t sb[$];
    logic [N-1:0] model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_load_reg u_shift_load_reg (
        .clk(clk), .rst(rst), .mode_load(mode_load), .rot_en(rot_en),
        .ser_in(ser_in), .word_in(word_in), .word_out(word_out), .ser_out(ser_out)
    );

    task automatic step(input logic r, input logic m, input logic ro,
                        input logic s, input logic [N-1:0] w, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; mode_load = m; rot_en = ro; ser_in = s; word_in = w;
        if (r)       model = '0;
        else if (m)  model = w;
        else         model = {(ro ? model[0] : s), model[N-1:1]};
        e.word = model;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        exp_t e;
        #1;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (word_out !== e.word) begin
                errors++;
                $display("FAIL %s word actual=%b expected=%b", e.tag, word_out, e.word);
            end
            checks++;
            if (ser_out !== e.word[0]) begin   // R6
                errors++;
                $display("FAIL R6 (%s) ser_out actual=%b expected=%b", e.tag, ser_out, e.word[0]);
            end
        end
    end

    initial begin
        logic [N-1:0] saved;
        // R1: reset with load and shift inputs active
        step(1, 1, 0, 1, 4'b1111, "R1");
        step(1, 0, 1, 1, 4'b1010, "R1");
        // R2: loads
        step(0, 1, 0, 0, 4'b1011, "R2");
        step(0, 1, 0, 1, 4'b0110, "R2");
        // R3 / R4: external serial shifts
        step(0, 0, 0, 1, 4'b0000, "R3");
        step(0, 0, 0, 0, 4'b1111, "R4");
        step(0, 0, 0, 1, 4'b0000, "R4");
        step(0, 0, 0, 1, 4'b0000, "R3");
        // R7: load ignores rot_en and ser_in
        step(0, 1, 1, 1, 4'b1001, "R7");
        step(0, 1, 1, 0, 4'b0100, "R7");
        // R5: rotate ignores ser_in
        step(0, 0, 1, 1, 4'b0000, "R5");
        step(0, 0, 1, 0, 4'b1111, "R5");
        // R8: four rotates restore each word
        foreach (saved[i]) ;
        for (int w = 1; w < 16; w += 3) begin
            step(0, 1, 0, 0, w[N-1:0], "R2");
            for (int k = 0; k < N; k++)
                step(0, 0, 1, ~k[0], 4'b0000, "R8");
        end
        // R1: reset mid-rotate
        step(0, 1, 0, 0, 4'b1110, "R2");
        step(1, 0, 1, 0, 4'b0000, "R1");
        // streaming a pattern serially
        for (int k = 0; k < 8; k++)
            step(0, 0, 0, k[1] ^ k[0], 4'b0000, "R4");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule